// File: doc/BRIEF.md
# Enable Window Data Stability Checker

This block watches a single enable line and a data bus of configurable width, and reports whenever the data moves while the enable is held. An enable window opens on the first sampled cycle with the enable high. The data may take a new value on that opening cycle, and again on the first cycle after the enable drops. From the second cycle of the window onwards the data is expected to hold.

An elaboration-time mode parameter chooses the reference the data is compared against. In previous-sample mode each cycle is compared with the one before it, so a single change raises a single report. In snapshot mode the value seen on the opening cycle is captured. Every later cycle of the window must equal that capture, so a bus that drifts away and settles on some other value is reported on every cycle it stays wrong.

The block drives two outputs. A registered strobe marks each offending cycle. A sticky flag records that at least one violation has occurred and holds until reset. The asynchronous active-low reset is released to the internal logic through a short synchronizer. While the reset is held, no checking takes place.

Top module: `stab_guard`

## Requirements
- R1: While `rst_n` is low, and after it is released, `viol_pulse` and `viol_sticky` read 0 until a violation is detected.
- R2: In previous-sample mode (`MODE` = CHK_PREV, encoded 0), a clock edge is offending when `win_en` is high at this edge and was high at the previous edge, and `win_data` differs from its value at the previous edge. `viol_pulse` is high for the one clock period that follows that edge.
- R3: A change of `win_data` at the edge where `win_en` is first sampled high, meaning the opening of a window, never raises `viol_pulse`.
- R4: A change of `win_data` at an edge where `win_en` is low, including the first low edge after a window, never raises `viol_pulse`.
- R5: In snapshot mode (`MODE` = CHK_SNAP, encoded 1), `win_data` is captured at the opening edge of each window. Every later edge of the same window at which `win_data` differs from the capture is offending. An edge at which the data has returned to the captured value is not offending.
- R6: `viol_sticky` becomes 1 together with the first `viol_pulse` and stays 1 until `rst_n` is asserted, regardless of later inputs.
- R7: The stored enable and data history is cleared by reset. The first edges after reset release therefore never compare against values seen before or during reset, and an enable that is already high counts as a window opening.
- R8: Each offending edge produces its own strobe cycle. Consecutive offending edges keep `viol_pulse` high on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| win_en | input | 1 | Enable whose high period defines the stability window |
| win_data | input | DATA_W | Data bus that must hold inside the window |
| viol_pulse | output | 1 | High for one cycle after each offending edge |
| viol_sticky | output | 1 | Latched once any violation is seen, cleared only by reset |

## Verification
A wrong stored enable shows up at the ports at once. A stale or uncleared history bit raises a strobe one cycle after the first edge following reset release, or after a window opening. A missing history bit hides the strobe after the first in-window change. A snapshot captured on the wrong edge appears as strobes where the two modes should disagree: a held drifted value, a value that returns to the capture, or a fresh window with new data. The two modes are therefore driven with the same stimulus and compared cycle by cycle. A sticky flag that fails to hold shows on the first quiet cycle after the strobe.

// File: rtl/stab_pkg.sv
package stab_pkg;
  typedef enum logic [0:0] {
    CHK_PREV = 1'b0,
    CHK_SNAP = 1'b1
  } stab_mode_e;
endpackage

// File: rtl/stab_rst_sync.sv
module stab_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/stab_history.sv
module stab_history #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              en_q,
  output logic [DATA_W-1:0] data_q
);
  logic              en_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    en_d   = en_in;
    data_d = data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      data_q <= '0;
    end else begin
      en_q   <= en_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/stab_snapshot.sv
module stab_snapshot #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] snap_q
);
  logic [DATA_W-1:0] snap_d;

  always_comb begin
    snap_d = snap_q;
    if (load) snap_d = data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(snap_q)); // R5
endmodule

// File: rtl/stab_flags.sv
module stab_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic viol,
  output logic pulse_q,
  output logic sticky_q
);
  logic pulse_d;
  logic sticky_d;
  logic sticky_ld;

  always_comb begin
    pulse_d   = viol;
    sticky_ld = viol & ~sticky_q;
    sticky_d  = sticky_q;
    if (sticky_ld) sticky_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q  <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      pulse_q  <= pulse_d;
      sticky_q <= sticky_d;
    end
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_q |=> sticky_q); // R6
  AST_PULSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> sticky_q); // R6
endmodule

// File: rtl/stab_guard.sv
module stab_guard
  import stab_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter stab_mode_e  MODE   = CHK_PREV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_en,
  input  logic [DATA_W-1:0] win_data,
  output logic              viol_pulse,
  output logic              viol_sticky
);
  localparam int unsigned SYNC_STAGES = 2;

  logic              rst_int_n;
  logic              en_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] ref_data;
  logic              in_window;
  logic              viol;

  stab_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  stab_history #(.DATA_W(DATA_W)) u_hist (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_in   (win_en),
    .data_in (win_data),
    .en_q    (en_q),
    .data_q  (data_q)
  );

  generate
    if (MODE == CHK_SNAP) begin : g_snap
      logic snap_load;
      assign snap_load = win_en & ~en_q;
      stab_snapshot #(.DATA_W(DATA_W)) u_snap (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .load    (snap_load),
        .data_in (win_data),
        .snap_q  (ref_data)
      );
    end else begin : g_prev
      assign ref_data = data_q;
      AST_PREV_CHANGE: assert property (@(posedge clk) disable iff (!rst_int_n)
        (win_en && $past(win_en) && $past(rst_int_n) && !$stable(win_data))
          |=> viol_pulse); // R2
    end
  endgenerate

  always_comb begin
    in_window = win_en & en_q;
    viol      = in_window & (win_data != ref_data);
  end

  stab_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .viol     (viol),
    .pulse_q  (viol_pulse),
    .sticky_q (viol_sticky)
  );

  AST_RST_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (!viol_pulse && !viol_sticky)); // R1
  AST_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(win_en) |=> !viol_pulse); // R3
  AST_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !win_en |=> !viol_pulse); // R4
endmodule

// File: tb/stab_guard_test.sv
module stab_guard_test;
  import stab_pkg::*;

  localparam int DW = 8;
  localparam time HALF = 4ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          win_en;
  logic [DW-1:0] win_data;
  logic          p_prev, s_prev, p_snap, s_snap;
  int            n_chk  = 0;
  int            n_fail = 0;

  always #HALF clk = ~clk;

  stab_guard #(.DATA_W(DW), .MODE(CHK_PREV)) uut (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .win_data(win_data),
    .viol_pulse(p_prev), .viol_sticky(s_prev));

  stab_guard #(.DATA_W(DW), .MODE(CHK_SNAP)) uut_snap (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .win_data(win_data),
    .viol_pulse(p_snap), .viol_sticky(s_snap));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // drive one cycle, then check both strobes just after the sampling edge
  task automatic step(input logic en, input logic [DW-1:0] d,
                      input logic exp_prev, input logic exp_snap, input string req);
    @(negedge clk);
    win_en   = en;
    win_data = d;
    @(posedge clk);
    #2;
    chk(req, "pulse prev-mode", p_prev, exp_prev);
    chk(req, "pulse snap-mode", p_snap, exp_snap);
  endtask

  task automatic chk_sticky(input string req, input logic exp_prev, input logic exp_snap);
    chk(req, "sticky prev-mode", s_prev, exp_prev);
    chk(req, "sticky snap-mode", s_snap, exp_snap);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    win_en   = 1'b0;
    win_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // R1: outputs stay clear while reset is held, even with toggling inputs
  task automatic t_reset_hold();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      win_en   = i[0];
      win_data = 8'(8'h11 * i);
      @(posedge clk);
      #2;
      chk("R1", "pulse in reset", p_prev | p_snap, 1'b0);
      chk_sticky("R1", 1'b0, 1'b0);
    end
  endtask

  // R7: enable high across reset release, data changed at release
  task automatic t_release_window();
    @(negedge clk);
    rst_n    = 1'b0;
    win_en   = 1'b1;
    win_data = 8'h3C;
    repeat (2) @(negedge clk);
    rst_n    = 1'b1;
    win_data = 8'h5A;
    for (int i = 0; i < 6; i++) step(1'b1, 8'h5A, 1'b0, 1'b0, "R7");
    chk_sticky("R7", 1'b0, 1'b0);
    step(1'b0, 8'h5A, 1'b0, 1'b0, "R4");
  endtask

  // R2 R3 R4 R6: basic window, one in-window change
  task automatic t_basic();
    step(1'b0, 8'hAA, 1'b0, 1'b0, "R4");
    step(1'b1, 8'h55, 1'b0, 1'b0, "R3");
    chk_sticky("R1", 1'b0, 1'b0);
    step(1'b1, 8'h55, 1'b0, 1'b0, "R2");
    step(1'b1, 8'h66, 1'b1, 1'b1, "R2");
    chk_sticky("R6", 1'b1, 1'b1);
    step(1'b0, 8'h77, 1'b0, 1'b0, "R4");
    step(1'b0, 8'h12, 1'b0, 1'b0, "R4");
    step(1'b1, 8'h34, 1'b0, 1'b0, "R3");
    step(1'b1, 8'h34, 1'b0, 1'b0, "R3");
    step(1'b0, 8'h00, 1'b0, 1'b0, "R4");
    chk_sticky("R6", 1'b1, 1'b1);
  endtask

  // R5 R8: drift, hold, return, new value; then a fresh window
  task automatic t_modes();
    step(1'b1, 8'h10, 1'b0, 1'b0, "R3");
    step(1'b1, 8'h20, 1'b1, 1'b1, "R5");
    chk_sticky("R6", 1'b1, 1'b1);
    step(1'b1, 8'h20, 1'b0, 1'b1, "R5");
    step(1'b1, 8'h20, 1'b0, 1'b1, "R8");
    step(1'b1, 8'h10, 1'b1, 1'b0, "R5");
    step(1'b1, 8'h30, 1'b1, 1'b1, "R8");
    step(1'b0, 8'h40, 1'b0, 1'b0, "R4");
    step(1'b1, 8'h41, 1'b0, 1'b0, "R5");
    step(1'b1, 8'h41, 1'b0, 1'b0, "R5");
    step(1'b0, 8'h41, 1'b0, 1'b0, "R4");
  endtask

  // R6: sticky survives quiet cycles, R1: cleared by reset
  task automatic t_sticky();
    for (int i = 0; i < 3; i++) step(1'b0, 8'(i), 1'b0, 1'b0, "R4");
    chk_sticky("R6", 1'b1, 1'b1);
    do_reset();
    chk_sticky("R1", 1'b0, 1'b0);
    chk("R1", "pulse after reset", p_prev | p_snap, 1'b0);
  endtask

  initial begin
    rst_n    = 1'b0;
    win_en   = 1'b0;
    win_data = '0;
    t_reset_hold();
    do_reset();
    chk_sticky("R1", 1'b0, 1'b0);
    t_release_window();
    t_basic();
    do_reset();
    t_modes();
    t_sticky();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule